// File: doc/BRIEF.md
# Fetch-Side Program Trace Reporter

This block watches the instruction fetch stage of a pipelined, out-of-order core and produces one trace record per clock. The record says what kind of fetch happened, how many in-flight instructions the core discarded in that clock, whether the fetch began a new flow that cannot be derived from the program image, and, for such fetches, the address the flow moved to. An off-chip post-processor combines these records with the program image to rebuild the executed instruction stream.

Reporting happens at fetch rather than at retirement. Some fetched instructions never retire, so the cancel count is part of every record. The post-processor uses it to discard speculative fetches. Direct branch targets are never sent, because they can be computed from the code. Indirect branches, context switches, exception entries and both edges of a synchronization input all produce an address report.

Every input is sampled on a rising edge, and the record appears on registered outputs after that edge.

Top module: `ftrace_reporter`

## Requirements
- R1: `st_code` uses only these codes: 000 stall, 001 sequential, 010 branch not taken, 011 direct branch taken, 100 indirect branch taken, 101 exception taken. Codes 110 and 111 are never produced.
- R2: A cycle with `fetch_vld`=0 and `exc_take`=0 is reported as stall (000), with `st_indirect`=0 and `st_addr_vld`=0.
- R3: A fetch with `fetch_kind` 00 (sequential), 01 (not taken) or 10 (direct taken) is reported as 001, 010 or 011. No context switch, no exception and no pending synchronization mark may be present. Such a fetch raises neither `st_indirect` nor `st_addr_vld`.
- R4: A fetch with `fetch_kind` 11, a branch whose target comes from the link or count register, is reported as 100. It raises `st_indirect` and `st_addr_vld`, and `st_addr` equals `tgt_addr`.
- R5: A fetch with `ctx_sw`=1 (return from interrupt, or a write to the machine state register) is reported as 100 with `st_indirect`, `st_addr_vld` and `st_addr`=`tgt_addr`. This holds whatever `fetch_kind` is.
- R6: `exc_take`=1 is reported as 101 with `st_indirect`, `st_addr_vld` and `st_addr`=`exc_vec`. This takes precedence over `fetch_vld`, `fetch_kind` and `ctx_sw` in the same cycle.
- R7: Every cycle, including stalls, `st_cancel` equals `cancel_in`, saturated at 7.
- R8: A change of `sync_in`, rising or falling, marks the next fetch cycle. That is the first later cycle with `fetch_vld` or `exc_take`. The marked cycle raises `st_indirect` and `st_addr_vld` and reports `st_addr` (`tgt_addr`, or `exc_vec` on an exception), and its `st_code` is unchanged. A fetch in the same cycle as the change is not marked, and stall cycles do not clear the mark.
- R9: `st_addr` holds its value in every cycle in which `st_addr_vld` is 0.
- R10: All outputs are registered and describe the inputs sampled at the previous rising edge. During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_vld | input | 1 | A fetch occurs this cycle |
| fetch_kind | input | 2 | 00 sequential, 01 not taken, 10 direct taken, 11 register-target taken |
| ctx_sw | input | 1 | Fetch follows a return from interrupt or a machine state write |
| exc_take | input | 1 | Exception entry; the vector is fetched this cycle |
| exc_vec | input | ADDR_W | Exception vector address |
| tgt_addr | input | ADDR_W | Address fetched this cycle |
| sync_in | input | 1 | Trace synchronization level; either edge arms a mark |
| cancel_in | input | CIN_W | Instructions cancelled this cycle |
| st_code | output | 3 | Fetch status code |
| st_cancel | output | CNT_W | Saturated cancel count |
| st_indirect | output | 1 | Indirect change-of-flow attribute |
| st_addr | output | ADDR_W | Last reported flow address, held |
| st_addr_vld | output | 1 | One-cycle strobe: `st_addr` is new |

## Verification
The hardest case to reach is a synchronization edge followed by one or more stall cycles and then a fetch. In that case the mark has to survive the stalls, land on exactly one later fetch, and leave that fetch's status code alone. A related case is an edge that coincides with a fetch, where the mark must skip the current fetch. The bench drives both situations directly, including an edge on an exception cycle. It then runs long stretches that toggle `sync_in` often while stalls and exceptions are interleaved, and a behavioural model predicts every record.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

  typedef enum logic [2:0] {
    ST_STALL = 3'b000,
    ST_SEQ   = 3'b001,
    ST_BNT   = 3'b010,
    ST_DIR   = 3'b011,
    ST_IND   = 3'b100,
    ST_EXC   = 3'b101
  } fstat_e;

  typedef enum logic [1:0] {
    FK_SEQ = 2'b00,
    FK_NT  = 2'b01,
    FK_DIR = 2'b10,
    FK_IND = 2'b11
  } fkind_e;

  // Priority: exception, then stall, then indirect (register target or context switch), then direct kinds.
  function automatic fstat_e classify(input logic vld, input logic [1:0] kind,
                                      input logic ctx, input logic exc);
    if (exc)                             return ST_EXC;
    if (!vld)                            return ST_STALL;
    if (ctx || kind == 2'(FK_IND))       return ST_IND;
    case (kind)
      2'(FK_NT):  return ST_BNT;
      2'(FK_DIR): return ST_DIR;
      default:    return ST_SEQ;
    endcase
  endfunction

endpackage

// File: rtl/ftr_classify.sv
module ftr_classify #(
  parameter int ADDR_W = 32
) (
  input  logic              fetch_vld,
  input  logic [1:0]        fetch_kind,
  input  logic              ctx_sw,
  input  logic              exc_take,
  input  logic              sync_mark,
  input  logic [ADDR_W-1:0] exc_vec,
  input  logic [ADDR_W-1:0] tgt_addr,
  output ftr_pkg::fstat_e   code_nx,
  output logic              flow_ind,
  output logic              rpt_nx,
  output logic [ADDR_W-1:0] addr_nx
);
  import ftr_pkg::*;

  always_comb begin
    code_nx  = classify(fetch_vld, fetch_kind, ctx_sw, exc_take);
    flow_ind = (code_nx == ST_IND) || (code_nx == ST_EXC);
    rpt_nx   = flow_ind || sync_mark;
    addr_nx  = exc_take ? exc_vec : tgt_addr;
  end

  // A synchronization mark may only land on a real fetch cycle (R8).
  always_comb begin
    if (sync_mark) begin
      a_mark_on_fetch_r8: assert (fetch_vld || exc_take);
    end
  end

endmodule

// File: rtl/ftr_sync_mark.sv
module ftr_sync_mark (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic fetch_evt,
  output logic sync_mark
);
  logic sync_q;
  logic pend_q;
  logic sync_edge;

  assign sync_edge = sync_in ^ sync_q;
  assign sync_mark = pend_q && fetch_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
      pend_q <= (pend_q && !fetch_evt) || sync_edge;
    end
  end

  // A pending mark survives stall cycles (R8).
  p_mark_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !fetch_evt) |=> pend_q);

  // An edge always arms a mark for a later fetch (R8).
  p_edge_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> pend_q);

endmodule

// File: rtl/ftr_cancel_sat.sv
module ftr_cancel_sat #(
  parameter int CIN_W = 4,
  parameter int CNT_W = 3
) (
  input  logic [CIN_W-1:0] cancel_in,
  output logic [CNT_W-1:0] cancel_nx
);
  localparam int CMAX = (1 << CNT_W) - 1;

  function automatic logic [CNT_W-1:0] sat(input logic [CIN_W-1:0] v);
    if (int'(v) > CMAX) return CNT_W'(CMAX);
    return CNT_W'(v);
  endfunction

  assign cancel_nx = sat(cancel_in);

endmodule

// File: rtl/ftrace_reporter.sv
module ftrace_reporter #(
  parameter int ADDR_W = 32,
  parameter int CIN_W  = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [1:0]        fetch_kind,
  input  logic              ctx_sw,
  input  logic              exc_take,
  input  logic [ADDR_W-1:0] exc_vec,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              sync_in,
  input  logic [CIN_W-1:0]  cancel_in,
  output logic [2:0]        st_code,
  output logic [CNT_W-1:0]  st_cancel,
  output logic              st_indirect,
  output logic              st_addr_vld,
  output logic [ADDR_W-1:0] st_addr
);
  import ftr_pkg::*;

  localparam int CMAX = (1 << CNT_W) - 1;

  logic              fetch_evt;
  logic              sync_mark;
  fstat_e            code_nx;
  logic              flow_ind;
  logic              rpt_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [CNT_W-1:0]  cancel_nx;

  assign fetch_evt = fetch_vld || exc_take;

  ftr_sync_mark u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .fetch_evt (fetch_evt),
    .sync_mark (sync_mark)
  );

  ftr_classify #(.ADDR_W(ADDR_W)) u_cls (
    .fetch_vld  (fetch_vld),
    .fetch_kind (fetch_kind),
    .ctx_sw     (ctx_sw),
    .exc_take   (exc_take),
    .sync_mark  (sync_mark),
    .exc_vec    (exc_vec),
    .tgt_addr   (tgt_addr),
    .code_nx    (code_nx),
    .flow_ind   (flow_ind),
    .rpt_nx     (rpt_nx),
    .addr_nx    (addr_nx)
  );

  ftr_cancel_sat #(.CIN_W(CIN_W), .CNT_W(CNT_W)) u_cnc (
    .cancel_in (cancel_in),
    .cancel_nx (cancel_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_code     <= 3'b000;
      st_cancel   <= '0;
      st_indirect <= 1'b0;
      st_addr_vld <= 1'b0;
      st_addr     <= '0;
    end else begin
      st_code     <= code_nx;
      st_cancel   <= cancel_nx;
      st_indirect <= rpt_nx;
      st_addr_vld <= rpt_nx;
      if (rpt_nx) st_addr <= addr_nx;
    end
  end

  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code != 3'b110) && (st_code != 3'b111));

  p_stall_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld && !exc_take) |=> (st_code == 3'b000) && !st_indirect && !st_addr_vld);

  p_direct_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !exc_take && !ctx_sw && fetch_kind != 2'b11 && !sync_mark)
      |=> !st_addr_vld && !st_indirect);

  p_reg_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !exc_take && fetch_kind == 2'b11)
      |=> (st_code == 3'b100) && st_addr_vld && (st_addr == $past(tgt_addr)));

  p_ctx_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !exc_take && ctx_sw)
      |=> (st_code == 3'b100) && st_indirect && (st_addr == $past(tgt_addr)));

  p_exc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (st_code == 3'b101) && st_addr_vld && (st_addr == $past(exc_vec)));

  p_cancel_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cancel_in) >= CMAX) |=> (int'(st_cancel) == CMAX));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_addr_vld |-> $stable(st_addr));

  // Indirect flow (not sync) never goes unreported (R4, R5, R6).
  p_flow_reported_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flow_ind |=> st_indirect);

endmodule

// File: tb/ftrace_reporter_bench.sv
`timescale 1ns/1ps
module ftrace_reporter_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_vld = 1'b0;
  logic [1:0]    fetch_kind = 2'b00;
  logic          ctx_sw = 1'b0;
  logic          exc_take = 1'b0;
  logic [AW-1:0] exc_vec = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic          sync_in = 1'b0;
  logic [3:0]    cancel_in = '0;
  logic [2:0]    st_code;
  logic [2:0]    st_cancel;
  logic          st_indirect;
  logic          st_addr_vld;
  logic [AW-1:0] st_addr;

  always #2 clk = ~clk;

  ftrace_reporter u_ftrace_reporter (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_kind(fetch_kind),
    .ctx_sw(ctx_sw), .exc_take(exc_take), .exc_vec(exc_vec), .tgt_addr(tgt_addr),
    .sync_in(sync_in), .cancel_in(cancel_in), .st_code(st_code), .st_cancel(st_cancel),
    .st_indirect(st_indirect), .st_addr_vld(st_addr_vld), .st_addr(st_addr)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit            m_sprev = 1'b0;
  bit            m_pend = 1'b0;
  logic [AW-1:0] m_addr = '0;

  task automatic chk(input string tag, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // Called at a negative edge: apply inputs, predict, wait one cycle, compare.
  task automatic step(input bit vld, input int kind, input bit ctx, input bit exc,
                      input logic [AW-1:0] vec, input logic [AW-1:0] tgt,
                      input bit sync, input int cin);
    int    e_code;
    int    e_cnc;
    bit    fe;
    bit    edge_seen;
    bit    mark;
    bit    e_flag;
    string ctag;
    string ftag;
    fetch_vld = vld; fetch_kind = 2'(kind); ctx_sw = ctx; exc_take = exc;
    exc_vec = vec; tgt_addr = tgt; sync_in = sync; cancel_in = 4'(cin);

    fe = vld || exc;
    edge_seen = (sync != m_sprev);
    mark = m_pend && fe;
    m_pend = (m_pend && !fe) || edge_seen;
    m_sprev = sync;
    if (exc)                    begin e_code = 5; ctag = "R6"; end
    else if (!vld)              begin e_code = 0; ctag = "R2"; end
    else if (ctx)               begin e_code = 4; ctag = "R5"; end
    else if (kind == 3)         begin e_code = 4; ctag = "R4"; end
    else                        begin e_code = kind + 1; ctag = "R3"; end
    e_flag = (e_code >= 4) || mark;
    ftag = (mark && e_code < 4) ? "R8" : ctag;
    if (e_flag) m_addr = exc ? vec : tgt;
    e_cnc = (cin > 7) ? 7 : cin;

    @(negedge clk);
    chk(ctag, "status code", 64'(st_code), 64'(e_code));
    chk("R1", "code not reserved", 64'(st_code < 3'b110), 64'd1);
    chk(ftag, "indirect flag", 64'(st_indirect), 64'(e_flag));
    chk(ftag, "address strobe", 64'(st_addr_vld), 64'(e_flag));
    chk(e_flag ? ftag : "R9", "address", 64'(st_addr), 64'(m_addr));
    chk("R7", "cancel count", 64'(st_cancel), 64'(e_cnc));
  endtask

  task automatic idle(input int n, input bit sync);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 32'hDEAD_0000 + 32'(i), sync, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10", "reset code", 64'(st_code), 64'd0);
    chk("R10", "reset cancel", 64'(st_cancel), 64'd0);
    chk("R10", "reset flag", 64'(st_indirect), 64'd0);
    chk("R10", "reset strobe", 64'(st_addr_vld), 64'd0);
    chk("R10", "reset address", 64'(st_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 direct kinds, R4 register target, R5 context switch
    step(1, 0, 0, 0, '0, 32'h0000_1000, 0, 0);
    step(1, 1, 0, 0, '0, 32'h0000_1004, 0, 1);
    step(1, 2, 0, 0, '0, 32'h0000_2000, 0, 2);
    step(1, 3, 0, 0, '0, 32'h0000_3000, 0, 0);
    idle(2, 0);                                     // R9 hold
    step(1, 0, 1, 0, '0, 32'h0000_4000, 0, 0);       // R5
    step(1, 2, 1, 0, '0, 32'h0000_4100, 0, 0);       // R5 overrides direct kind
    // R6 exception beats branch and context switch, and also on no fetch
    step(1, 3, 1, 1, 32'h0000_0700, 32'h0000_5000, 0, 3);
    step(0, 0, 0, 1, 32'h0000_0500, 32'h0000_5100, 0, 0);
    // R7 cancel saturation, including on stalls
    step(0, 0, 0, 0, '0, '0, 0, 7);
    step(0, 0, 0, 0, '0, '0, 0, 8);
    step(1, 0, 0, 0, '0, 32'h0000_6000, 0, 15);
    // R8 rising edge, stalls, then fetch is marked with unchanged code
    step(0, 0, 0, 0, '0, '0, 1, 0);
    idle(3, 1);
    step(1, 1, 0, 0, '0, 32'h0000_7000, 1, 0);
    step(1, 0, 0, 0, '0, 32'h0000_7004, 1, 0);       // mark consumed
    // R8 falling edge coincident with a fetch: the next fetch is marked
    step(1, 0, 0, 0, '0, 32'h0000_8000, 0, 0);
    step(1, 2, 0, 0, '0, 32'h0000_8004, 0, 0);
    // R8 edge then an exception consumes the mark
    step(1, 0, 0, 0, '0, 32'h0000_9000, 1, 0);
    step(0, 0, 0, 1, 32'h0000_0900, 32'h0000_9004, 1, 0);
    step(1, 0, 0, 0, '0, 32'h0000_9008, 1, 0);

    // mixed stimulus
    for (int i = 0; i < 5000; i++) begin
      bit s;
      s = sync_in;
      if ($urandom_range(0, 7) == 0) s = !s;
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 3)),
           $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
           32'($urandom), 32'($urandom), s, int'($urandom_range(0, 15)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule